// File: doc/BRIEF.md
# Keyed-Control Watchdog Timer

This peripheral counts upward on a slow tick and asks for a system reset when the count rolls over from all ones. Software keeps it alive by writing a fresh value to the trigger register, which reloads the count from the load register. Counting can only be switched on or off by writing a fixed pair of key words, in order, to the start/stop register. Stray writes therefore cannot change whether the watchdog runs.

Writes to the control, load, trigger and start/stop registers are posted. Each one is held for a fixed number of slow ticks, which stands in for the crossing into the slow domain, and only then takes effect. A status register shows one pending bit per posted register. While a register's bit is set, further writes to that register are dropped. The slow tick arrives as a one-cycle pulse in the bus clock domain. Real synchronizers are not modelled.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, counting is disabled, the counter, load, control and configuration registers read 0, the pending bitmap reads 0 and `rst_req` is low.
- R2: A committed write of 0xBBBB to the start/stop register, followed directly by a committed write of 0x4444, enables counting.
- R3: A committed 0xAAAA followed directly by a committed 0x5555 disables counting, and the counter then holds its value.
- R4: If any word other than the matching second key follows a first key, the sequencer returns to idle and the enable state is unchanged. A lone second key has no effect.
- R5: The pending bitmap (read address 5) has bit 0 for control, bit 2 for load, bit 3 for trigger and bit 4 for start/stop. A bit sets on an accepted write and clears after HOLD_TICKS slow ticks, at which point the write takes effect. All other bits read 0.
- R6: A write to a posted register while its pending bit is set is ignored.
- R7: A committed trigger write whose data differs from the last trigger value reloads the counter from the load register. Repeating the same value has no effect. The trigger value is 0 after reset.
- R8: In the control register, bit 5 enables the prescaler and bits 4:2 hold PTV. With the prescaler on, the counter advances once every 2^PTV ticks. With it off, the counter advances on every tick. The control register reads back the committed value.
- R9: When an enabled counter advances from all ones, `rst_req` is high for exactly one clock and the counter is reloaded from the load register.
- R10: Bit 0 of the configuration register (address 0) is stored directly, without posting, and reads back. Its other bits read 0.
- R11: While enabled, the counter advances upward on slow ticks. While disabled, it holds its value.
- R12: The word addresses are: 0 configuration, 1 control, 2 counter (read-only; writes are ignored), 3 load, 4 trigger, 5 pending bitmap (read-only), 6 start/stop. Read data appears on `bus_rdata` on the clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rst_req | output | 1 | One-cycle reset request on rollover |

## Verification
The assertions assume that `slow_tick` is a single-cycle pulse, that every bus access is a one-cycle strobe, and that reset is held for at least one clock before the first access. The bench drives all strobes and ticks at falling edges and releases them after one cycle. It separates ticks by idle cycles, so every commit and its effect settle before the next tick, and it never overlaps a read with a write.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_SYSCFG = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_LOAD   = 3'd3;
  localparam logic [ADDR_W-1:0] A_TRIG   = 3'd4;
  localparam logic [ADDR_W-1:0] A_PEND   = 3'd5;
  localparam logic [ADDR_W-1:0] A_KEYS   = 3'd6;

  // posted slots and their bit in the pending bitmap
  localparam int NSLOT   = 4;
  localparam int SL_CTRL = 0;
  localparam int SL_LOAD = 1;
  localparam int SL_TRIG = 2;
  localparam int SL_KEYS = 3;
  localparam int PEND_W  = 5;
  localparam int SLOT_BIT [NSLOT] = '{0, 2, 3, 4};

  // control register fields
  localparam int CTRL_PTV_LSB = 2;
  localparam int CTRL_PRE_BIT = 5;

  // key words
  localparam logic [15:0] KEY_ARM1 = 16'hBBBB;
  localparam logic [15:0] KEY_ARM2 = 16'h4444;
  localparam logic [15:0] KEY_DIS1 = 16'hAAAA;
  localparam logic [15:0] KEY_DIS2 = 16'h5555;

  typedef enum logic [1:0] {KS_IDLE, KS_ARM1, KS_DIS1} wdk_key_e;
endpackage

// File: rtl/wdk_posted.sv
module wdk_posted #(
  parameter int DW         = 32,
  parameter int HOLD_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          commit,
  output logic [DW-1:0] data
);
  localparam int RW = $clog2(HOLD_TICKS + 1);

  logic [RW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      commit <= 1'b0;
      data   <= '0;
      remain <= '0;
    end else begin
      commit <= 1'b0;
      if (!busy) begin
        if (wr_en) begin
          busy   <= 1'b1;
          data   <= wr_data;
          remain <= RW'(HOLD_TICKS);
        end
      end else if (tick) begin
        if (remain == RW'(1)) begin
          busy   <= 1'b0;
          commit <= 1'b1;
        end
        remain <= remain - 1'b1;
      end
    end
  end

  // R6: a write arriving while busy leaves the staged word untouched
  a_r6_drop_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy && wr_en |=> $stable(data));

  // R5: a commit only ends a pending period
  a_r5_commit_ends_pending: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(busy) && !busy);
endmodule

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
  import wdk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  logic [DW-1:0] word,
  output logic          armed
);
  wdk_key_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= KS_IDLE;
      armed <= 1'b0;
    end else if (commit) begin
      case (state)
        KS_IDLE: begin
          if (word == DW'(KEY_ARM1))      state <= KS_ARM1;
          else if (word == DW'(KEY_DIS1)) state <= KS_DIS1;
        end
        KS_ARM1: begin
          if (word == DW'(KEY_ARM2)) armed <= 1'b1;
          state <= KS_IDLE;
        end
        KS_DIS1: begin
          if (word == DW'(KEY_DIS2)) armed <= 1'b0;
          state <= KS_IDLE;
        end
        default: state <= KS_IDLE;
      endcase
    end
  end

  // R4: enable state moves only when a key word is committed
  a_r4_armed_only_on_commit: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(armed));

  // R2: arming needs the first arm key beforehand
  a_r2_arm_after_first_key: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(state) == KS_ARM1);

  // R3: disarming needs the first disarm key beforehand
  a_r3_disarm_after_first_key: assert property (@(posedge clk) disable iff (rst)
    $fell(armed) |-> $past(state) == KS_DIS1);
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int CNT_W = 32,
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             pre_en,
  input  logic [PTV_W-1:0] ptv,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam int PRE_W = (1 << PTV_W) - 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_lim;
  logic             pre_hit;

  assign pre_lim = (PRE_W'(1) << ptv) - PRE_W'(1);
  assign pre_hit = !pre_en || (pre_cnt >= pre_lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pre_cnt <= '0;
      wrap    <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (reload) begin
        cnt     <= load_val;
        pre_cnt <= '0;
      end else if (tick && run) begin
        if (pre_hit) begin
          pre_cnt <= '0;
          if (cnt == {CNT_W{1'b1}}) begin
            cnt  <= load_val;
            wrap <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
    end
  end

  // R9: the reset request lasts a single clock
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wrap |=> !wrap);

  // R9: a request follows an all-ones count and lands on the load value
  a_r9_wrap_from_max: assert property (@(posedge clk) disable iff (rst)
    wrap |-> ($past(cnt) == {CNT_W{1'b1}}) && (cnt == $past(load_val)));

  // R11: a stopped counter holds unless reloaded
  a_r11_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    !run && !reload |=> $stable(cnt));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdk_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 32,
  parameter int PTV_W      = 3,
  parameter int HOLD_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  logic              wr_stb;
  logic              rd_stb;
  logic [NSLOT-1:0]  slot_wr;
  logic [NSLOT-1:0]  slot_busy;
  logic [NSLOT-1:0]  slot_commit;
  logic [DATA_W-1:0] slot_data [NSLOT];
  logic [PEND_W-1:0] pend;

  logic              cfg_autogate;
  logic              pre_en_q;
  logic [PTV_W-1:0]  ptv_q;
  logic [CNT_W-1:0]  load_q;
  logic [DATA_W-1:0] last_trig;
  logic              armed;
  logic              reload;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] load_word;
  logic              unused_sink;

  assign wr_stb = bus_sel && bus_we;
  assign rd_stb = bus_sel && !bus_we;

  always_comb begin
    slot_wr          = '0;
    slot_wr[SL_CTRL] = wr_stb && (bus_addr == A_CTRL);
    slot_wr[SL_LOAD] = wr_stb && (bus_addr == A_LOAD);
    slot_wr[SL_TRIG] = wr_stb && (bus_addr == A_TRIG);
    slot_wr[SL_KEYS] = wr_stb && (bus_addr == A_KEYS);
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    wdk_posted #(.DW(DATA_W), .HOLD_TICKS(HOLD_TICKS)) u_post (
      .clk     (clk),
      .rst     (rst),
      .tick    (slow_tick),
      .wr_en   (slot_wr[g]),
      .wr_data (bus_wdata),
      .busy    (slot_busy[g]),
      .commit  (slot_commit[g]),
      .data    (slot_data[g])
    );
  end

  always_comb begin
    pend = '0;
    for (int i = 0; i < NSLOT; i++) pend[SLOT_BIT[i]] = slot_busy[i];
  end

  assign ctrl_word = slot_data[SL_CTRL];
  assign load_word = slot_data[SL_LOAD];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_autogate <= 1'b0;
      pre_en_q     <= 1'b0;
      ptv_q        <= '0;
      load_q       <= '0;
      last_trig    <= '0;
    end else begin
      if (wr_stb && (bus_addr == A_SYSCFG)) cfg_autogate <= bus_wdata[0];
      if (slot_commit[SL_CTRL]) begin
        pre_en_q <= ctrl_word[CTRL_PRE_BIT];
        ptv_q    <= ctrl_word[CTRL_PTV_LSB +: PTV_W];
      end
      if (slot_commit[SL_LOAD]) load_q <= load_word[CNT_W-1:0];
      if (slot_commit[SL_TRIG]) last_trig <= slot_data[SL_TRIG];
    end
  end

  assign reload = slot_commit[SL_TRIG] && (slot_data[SL_TRIG] != last_trig);

  wdk_keyseq #(.DW(DATA_W)) u_keys (
    .clk    (clk),
    .rst    (rst),
    .commit (slot_commit[SL_KEYS]),
    .word   (slot_data[SL_KEYS]),
    .armed  (armed)
  );

  wdk_counter #(.CNT_W(CNT_W), .PTV_W(PTV_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (slow_tick),
    .run      (armed),
    .pre_en   (pre_en_q),
    .ptv      (ptv_q),
    .reload   (reload),
    .load_val (load_q),
    .cnt      (cnt),
    .wrap     (rst_req)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_SYSCFG: rd_mux[0] = cfg_autogate;
      A_CTRL: begin
        rd_mux[CTRL_PRE_BIT]               = pre_en_q;
        rd_mux[CTRL_PTV_LSB +: PTV_W]      = ptv_q;
      end
      A_COUNT:  rd_mux = DATA_W'(cnt);
      A_LOAD:   rd_mux = DATA_W'(load_q);
      A_PEND:   rd_mux = DATA_W'(pend);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_stb) bus_rdata <= rd_mux;
  end

  assign unused_sink = ^{ctrl_word, load_word};

  // R10: the configuration bit moves only on a write to its address
  a_r10_cfg_only_on_write: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && (bus_addr == A_SYSCFG)) |=> $stable(cfg_autogate));

  // R7: a trigger that repeats the last value leaves the stored value alone
  a_r7_trig_tracks_commit: assert property (@(posedge clk) disable iff (rst)
    !slot_commit[SL_TRIG] |=> $stable(last_trig));

  // R8: committed control fields change only on a control commit
  a_r8_ctrl_on_commit: assert property (@(posedge clk) disable iff (rst)
    !slot_commit[SL_CTRL] |=> $stable(pre_en_q) && $stable(ptv_q));
endmodule

// File: tb/wdog_keyed_bench.sv
module wdog_keyed_bench;
  localparam int DW = 32;
  localparam logic [2:0] AD_CFG = 3'd0, AD_CTRL = 3'd1, AD_CNT = 3'd2,
                         AD_LOAD = 3'd3, AD_TRIG = 3'd4, AD_PEND = 3'd5, AD_KEYS = 3'd6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          slow_tick = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdog_keyed #(.DATA_W(DW), .CNT_W(8), .PTV_W(3), .HOLD_TICKS(2)) u_wdog_keyed (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1;
      @(negedge clk); slow_tick = 0;
      @(negedge clk);
    end
  endtask

  task automatic posted(input logic [2:0] a, input logic [DW-1:0] d);
    wr(a, d);
    ticks(2);
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    rd(AD_CFG, v);  chk("R1 cfg", v, 0);
    rd(AD_CTRL, v); chk("R1 ctrl", v, 0);
    rd(AD_CNT, v);  chk("R1 counter", v, 0);
    rd(AD_LOAD, v); chk("R1 load", v, 0);
    rd(AD_PEND, v); chk("R1 pending", v, 0);
    chk("R1 rst_req", DW'(rst_req), 0);
  endtask

  task automatic t_sysconf;
    logic [DW-1:0] v;
    wr(AD_CFG, 32'hFFFF_FFFF); rd(AD_CFG, v); chk("R10 cfg set", v, 1);
    wr(AD_CFG, 32'h0000_0000); rd(AD_CFG, v); chk("R10 cfg clear", v, 0);
    wr(AD_CFG, 32'h0000_0001);
  endtask

  task automatic t_pending;
    logic [DW-1:0] v;
    wr(AD_LOAD, 32'h10);
    rd(AD_PEND, v); chk("R5 load pending", v, 32'h04);
    wr(AD_LOAD, 32'h20);
    ticks(1);
    rd(AD_PEND, v); chk("R5 still pending", v, 32'h04);
    ticks(1);
    rd(AD_PEND, v); chk("R5 cleared", v, 0);
    rd(AD_LOAD, v); chk("R6 second write dropped", v, 32'h10);
    wr(AD_TRIG, 32'h1);
    rd(AD_PEND, v); chk("R5 trigger pending", v, 32'h08);
    ticks(2);
    rd(AD_CNT, v);  chk("R7 new trigger reloads", v, 32'h10);
    wr(AD_CNT, 32'h55);
    rd(AD_CNT, v);  chk("R12 counter read-only", v, 32'h10);
    wr(AD_CTRL, 32'h0);
    wr(AD_KEYS, 32'hBBBB);
    rd(AD_PEND, v); chk("R5 ctrl+keys pending", v, 32'h11);
    ticks(2);
    rd(AD_PEND, v); chk("R5 both cleared", v, 0);
  endtask

  task automatic t_badkey;
    logic [DW-1:0] v;
    posted(AD_KEYS, 32'h1234);
    posted(AD_KEYS, 32'h4444);
    ticks(3);
    rd(AD_CNT, v); chk("R4 wrong second key leaves disabled", v, 32'h10);
  endtask

  task automatic t_arm;
    logic [DW-1:0] v;
    posted(AD_KEYS, 32'hBBBB);
    posted(AD_KEYS, 32'h4444);
    rd(AD_CNT, v); chk("R2 no count before enable", v, 32'h10);
    ticks(5);
    rd(AD_CNT, v); chk("R2 R11 counts up when armed", v, 32'h15);
  endtask

  task automatic t_trigger;
    logic [DW-1:0] v;
    posted(AD_TRIG, 32'h1);
    rd(AD_CNT, v); chk("R7 repeated value no reload", v, 32'h17);
    posted(AD_TRIG, 32'h2);
    rd(AD_CNT, v); chk("R7 changed value reloads", v, 32'h10);
  endtask

  task automatic t_prescale;
    logic [DW-1:0] v;
    posted(AD_CTRL, 32'h28);
    rd(AD_CNT, v);  chk("R8 old rate during pending", v, 32'h12);
    rd(AD_CTRL, v); chk("R8 ctrl readback", v, 32'h28);
    ticks(3);
    rd(AD_CNT, v);  chk("R8 no step before 4 ticks", v, 32'h12);
    ticks(1);
    rd(AD_CNT, v);  chk("R8 step on 4th tick", v, 32'h13);
    ticks(8);
    rd(AD_CNT, v);  chk("R8 two more steps", v, 32'h15);
    posted(AD_CTRL, 32'h0);
    rd(AD_CNT, v);  chk("R8 divided during pending", v, 32'h15);
    ticks(1);
    rd(AD_CNT, v);  chk("R8 every tick when off", v, 32'h16);
  endtask

  task automatic t_overflow;
    logic [DW-1:0] v;
    posted(AD_LOAD, 32'hFC);
    posted(AD_TRIG, 32'h3);
    rd(AD_CNT, v); chk("R7 reload to new load", v, 32'hFC);
    ticks(3);
    rd(AD_CNT, v); chk("R11 at max", v, 32'hFF);
    chk("R9 no request yet", DW'(rst_req), 0);
    @(negedge clk); slow_tick = 1;
    @(negedge clk); slow_tick = 0;
    chk("R9 request raised", DW'(rst_req), 1);
    @(negedge clk);
    chk("R9 request one cycle", DW'(rst_req), 0);
    rd(AD_CNT, v); chk("R9 reloaded on wrap", v, 32'hFC);
  endtask

  task automatic t_disarm;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    posted(AD_KEYS, 32'hAAAA);
    posted(AD_KEYS, 32'h5555);
    rd(AD_CNT, a); chk("R3 value at disarm", a, 32'hFC);
    ticks(3);
    rd(AD_CNT, b); chk("R3 R11 holds when disarmed", b, a);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_sysconf();
    t_pending();
    t_badkey();
    t_arm();
    t_trigger();
    t_prescale();
    t_overflow();
    t_disarm();
    done = 1;
    summary();
    $finish;
  end
endmodule